// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends one CEC message over a single open-drain, wired-AND bus line. The host supplies up to sixteen bytes and a byte count, and picks how long the line must be seen idle beforehand. After the line has been idle for that long, the block sends a start bit. Each byte then follows, most significant bit first, with an end-of-message bit and an acknowledge slot after it. Every waveform width is counted in ticks of a slow CEC time base, which arrives as a one-cycle enable on `tick`.

The block only ever pulls the line low, through `drive_low`, which feeds the pad's output enable. It reads the resolved bus level back on `line_in`, which is already synchronised. It uses that level for three things: to restart the idle count, to detect a lost arbitration, and to judge each acknowledge slot. When the frame ends it pulses `done` together with an accepted or rejected result. If another initiator takes the line, it pulses `arb_lost` instead. Byte 0 is the header: initiator address in bits 7:4, destination address in bits 3:0. Destination 4'hF means broadcast.

Top module: `cec_frame_tx`

## Requirements
- R1: A synchronous reset, whether held at power-up or applied during a frame, leaves `drive_low`, `busy`, `done` and `arb_lost` low.
- R2: `free_sel` chooses the required idle time: 0 selects 3 bit periods, 1 selects 5, 2 selects 7 (351, 585 or 819 ticks by default), and 3 selects no wait. With a wait selected, the start bit begins on the tick that completes that many consecutive ticks of high line, and any low tick restarts the count. With no wait, it begins on the first tick after `tx_start` is accepted.
- R3: The start bit holds the line low for 180 ticks within a 220-tick period.
- R4: Data bits go out MSB first, byte 0 first. A 0 is low for 73 ticks, a 1 is low for 29 ticks, and every bit period is 117 ticks.
- R5: The 9th bit after each byte is the end-of-message bit: 1 after the last byte, 0 otherwise.
- R6: The 10th bit after each byte is the acknowledge slot. It is sent as a logical 1, and the line is sampled on tick 49 of the slot. For a directed frame (destination not 4'hF) a low level means accepted. For a broadcast frame a high level means accepted.
- R7: A rejected acknowledge slot ends the frame at the end of that slot, with `acked` = 0. No further bytes are sent.
- R8: `done` is high for exactly one clock, on the tick that ends the final acknowledge slot. `acked` carries the result and `busy` is low from that clock on.
- R9: If the line reads low on a tick while the block is releasing it inside a data or end-of-message bit (tick count past the low width), the block releases the line at once, pulses `arb_lost`, returns to idle and raises no `done`.
- R10: `tx_start` is ignored while `busy` is high. The frame in progress is unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle CEC time-base enable |
| tx_start | input | 1 | Request to send the presented message |
| tx_len | input | 5 | Number of bytes, 1 to MAX_BYTES |
| tx_data | input | 128 | Message bytes, byte i in bits 8i+7:8i |
| free_sel | input | 2 | Idle-time selection (see R2) |
| line_in | input | 1 | Synchronised bus level |
| drive_low | output | 1 | Pad output enable; 1 pulls the line low |
| busy | output | 1 | A frame is waiting or in progress |
| done | output | 1 | One-clock frame completion pulse |
| acked | output | 1 | Result of the last completed frame |
| arb_lost | output | 1 | One-clock lost-arbitration pulse |

## Verification
A wrong bit or byte index shows up at the pad within one bit period. The low time of some bit is then 73 where 29 was expected, or the reverse, or the end-of-message bit lands in the wrong position. A slip in the tick counter changes a measured low width or period, in the very bit where it happens. A wrong acknowledge polarity or stale rejection state appears on `acked`, or as a frame that is too short or too long, at the `done` pulse. A faulty idle counter moves the first falling edge by a whole number of ticks.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_DATA
  } tx_state_t;

  localparam logic [1:0] FREE_NONE = 2'd3;
  localparam logic [3:0] ADDR_ALL  = 4'hF;
  localparam logic [3:0] SLOT_EOM  = 4'd8;
  localparam logic [3:0] SLOT_ACK  = 4'd9;

  // Idle length in bit periods for a given selection code.
  function automatic int free_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    free_bits = 3;
      2'd1:    free_bits = 5;
      default: free_bits = 7;
    endcase
  endfunction

endpackage

// File: rtl/cec_free_timer.sv
module cec_free_timer
  import cec_tx_pkg::*;
#(
  parameter int BIT_PER = 117,
  parameter int CW      = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       run,
  input  logic       line_hi,
  input  logic [1:0] sel,
  output logic       ok
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] need;

  always_comb begin
    need = CW'(free_bits(sel) * BIT_PER);
    ok   = run && tick &&
           ((sel == FREE_NONE) || (line_hi && (cnt == need - CW'(1))));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= line_hi ? cnt + CW'(1) : '0;
    end
  end

endmodule

// File: rtl/cec_bit_timer.sv
module cec_bit_timer #(
  parameter int CW        = 10,
  parameter int SAMPLE_AT = 49
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic          abort,
  input  logic [CW-1:0] low_len,
  input  logic [CW-1:0] per_len,
  output logic          pull,
  output logic          last,
  output logic          sample,
  output logic          released
);

  logic          active;
  logic [CW-1:0] cnt;
  logic [CW-1:0] low_q;
  logic [CW-1:0] per_q;

  always_comb begin
    last     = active && tick && (cnt == per_q - CW'(1));
    sample   = active && tick && (cnt == CW'(SAMPLE_AT));
    released = active && (cnt > low_q);
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active <= 1'b0;
      pull   <= 1'b0;
      cnt    <= '0;
      low_q  <= '0;
      per_q  <= '0;
    end else if (load) begin
      active <= 1'b1;
      pull   <= 1'b1;
      cnt    <= '0;
      low_q  <= low_len;
      per_q  <= per_len;
    end else if (active && tick) begin
      if (cnt == per_q - CW'(1)) begin
        active <= 1'b0;
        pull   <= 1'b0;
      end else begin
        cnt  <= cnt + CW'(1);
        pull <= (cnt + CW'(1)) < low_q;
      end
    end
  end

endmodule

// File: rtl/cec_frame_tx.sv
module cec_frame_tx
  import cec_tx_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int START_LOW = 180,
  parameter int START_PER = 220,
  parameter int ZERO_LOW  = 73,
  parameter int ONE_LOW   = 29,
  parameter int BIT_PER   = 117,
  parameter int SAMPLE_AT = 49,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int IDX_W    = $clog2(MAX_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   tx_start,
  input  logic [LEN_W-1:0]       tx_len,
  input  logic [MAX_BYTES*8-1:0] tx_data,
  input  logic [1:0]             free_sel,
  input  logic                   line_in,
  output logic                   drive_low,
  output logic                   busy,
  output logic                   done,
  output logic                   acked,
  output logic                   arb_lost
);

  localparam int LONGEST = (START_PER > 7 * BIT_PER) ? START_PER : 7 * BIT_PER;
  localparam int CW      = $clog2(LONGEST + 1);

  tx_state_t        state;
  logic [7:0]       msg_q [MAX_BYTES];
  logic [LEN_W-1:0] len_q;
  logic [1:0]       sel_q;
  logic [IDX_W-1:0] byte_q, nxt_byte;
  logic [3:0]       bit_q, nxt_bit;
  logic             rej_q;

  logic             free_ok, load, finish, nxt_val, arb_hit;
  logic             bit_last, bit_sample, bit_rel;
  logic [CW-1:0]    low_len, per_len;
  logic             last_byte, directed;

  cec_free_timer #(.BIT_PER(BIT_PER), .CW(CW)) u_free (
    .clk(clk), .rst(rst), .tick(tick), .run(state == ST_WAIT),
    .line_hi(line_in), .sel(sel_q), .ok(free_ok)
  );

  cec_bit_timer #(.CW(CW), .SAMPLE_AT(SAMPLE_AT)) u_bit (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .abort(arb_hit),
    .low_len(low_len), .per_len(per_len), .pull(drive_low),
    .last(bit_last), .sample(bit_sample), .released(bit_rel)
  );

  assign busy      = (state != ST_IDLE);
  assign last_byte = (LEN_W'(byte_q) + LEN_W'(1)) == len_q;
  assign directed  = (msg_q[0][3:0] != ADDR_ALL);
  assign arb_hit   = (state == ST_DATA) && (bit_q != SLOT_ACK) && bit_rel &&
                     tick && !line_in;

  // Sequencing: which bit starts next, and whether the frame ends.
  always_comb begin
    nxt_byte = byte_q;
    nxt_bit  = bit_q + 4'd1;
    load     = 1'b0;
    finish   = 1'b0;
    case (state)
      ST_WAIT:  load = free_ok;
      ST_START: begin
        nxt_byte = '0;
        nxt_bit  = '0;
        load     = bit_last;
      end
      ST_DATA: begin
        if (bit_last && !arb_hit) begin
          if (bit_q == SLOT_ACK) begin
            if (last_byte || rej_q) begin
              finish = 1'b1;
            end else begin
              load     = 1'b1;
              nxt_byte = byte_q + IDX_W'(1);
              nxt_bit  = '0;
            end
          end else begin
            load = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    if (nxt_bit < SLOT_EOM) begin
      nxt_val = msg_q[nxt_byte][3'd7 - nxt_bit[2:0]];
    end else if (nxt_bit == SLOT_EOM) begin
      nxt_val = (LEN_W'(nxt_byte) + LEN_W'(1)) == len_q;
    end else begin
      nxt_val = 1'b1;
    end
    if (state == ST_WAIT) begin
      low_len = CW'(START_LOW);
      per_len = CW'(START_PER);
    end else begin
      low_len = nxt_val ? CW'(ONE_LOW) : CW'(ZERO_LOW);
      per_len = CW'(BIT_PER);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      len_q    <= '0;
      sel_q    <= FREE_NONE;
      byte_q   <= '0;
      bit_q    <= '0;
      rej_q    <= 1'b0;
      done     <= 1'b0;
      acked    <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      done     <= 1'b0;
      arb_lost <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (tx_start && (tx_len != '0) && (tx_len <= LEN_W'(MAX_BYTES))) begin
            len_q <= tx_len;
            sel_q <= free_sel;
            rej_q <= 1'b0;
            state <= ST_WAIT;
          end
        end
        ST_WAIT:  if (load) state <= ST_START;
        ST_START: begin
          if (load) begin
            state  <= ST_DATA;
            byte_q <= nxt_byte;
            bit_q  <= nxt_bit;
          end
        end
        ST_DATA: begin
          if (arb_hit) begin
            state    <= ST_IDLE;
            arb_lost <= 1'b1;
          end else begin
            if (bit_sample && (bit_q == SLOT_ACK)) begin
              rej_q <= directed ? line_in : !line_in;
            end
            if (finish) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              acked <= !rej_q;
            end else if (load) begin
              byte_q <= nxt_byte;
              bit_q  <= nxt_bit;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Message capture; a plain register file written once per frame.
  always_ff @(posedge clk) begin
    if ((state == ST_IDLE) && tx_start) begin
      for (int i = 0; i < MAX_BYTES; i++) begin
        msg_q[i] <= tx_data[8*i +: 8];
      end
    end
  end

endmodule

// File: rtl/cec_frame_tx_chk.sv
module cec_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic drive_low,
  input logic busy,
  input logic done,
  input logic arb_lost
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!drive_low && !busy && !done && !arb_lost));

  assert_no_pull_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !drive_low);

  assert_pull_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_low) |-> $past(tick));

  assert_pull_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
    drive_low |-> busy);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !drive_low));

  assert_arb_release_R9: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> (!drive_low && !busy && !done));

endmodule

bind cec_frame_tx cec_frame_tx_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .drive_low(drive_low),
  .busy(busy), .done(done), .arb_lost(arb_lost)
);

// File: tb/cec_frame_tx_test.sv
module cec_frame_tx_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b1;
  logic         tx_start = 1'b0;
  logic [4:0]   tx_len = '0;
  logic [127:0] tx_data = '0;
  logic [1:0]   free_sel = 2'd3;
  logic         ext_low = 1'b0;
  logic         fol_low;
  logic         line_in;
  logic         drive_low, busy, done, acked, arb_lost;

  int checks = 0, errors = 0, cyc = 0;
  int nb = 0, run = 0, t_first = 0, c_set = 0, fol_cnt = 0;
  int done_cnt = 0, arb_cnt = 0;
  int low_a [64];
  int per_a [64];
  logic [2:0] ack_mask = '0;
  logic pl = 1'b0;
  logic last_acked = 1'b0;

  assign fol_low = (fol_cnt > 0);
  assign line_in = !(drive_low || fol_low || ext_low);

  cec_frame_tx uut (
    .clk(clk), .rst(rst), .tick(tick), .tx_start(tx_start), .tx_len(tx_len),
    .tx_data(tx_data), .free_sel(free_sel), .line_in(line_in),
    .drive_low(drive_low), .busy(busy), .done(done), .acked(acked),
    .arb_lost(arb_lost)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Pad monitor and follower model.
  always @(negedge clk) begin
    if (fol_cnt > 0) fol_cnt = fol_cnt - 1;
    if (drive_low && !pl) begin
      if (nb > 0) per_a[nb-1] = run;
      else t_first = cyc;
      low_a[nb] = 0;
      run = 0;
      if (nb > 0 && nb % 10 == 0 && nb / 10 <= 3 && ack_mask[nb/10 - 1]) fol_cnt = 61;
      nb = nb + 1;
    end else if (done && nb > 0) begin
      per_a[nb-1] = run;
    end
    if (nb > 0) begin
      run = run + 1;
      if (drive_low) low_a[nb-1] = low_a[nb-1] + 1;
    end
    if (done) begin
      done_cnt = done_cnt + 1;
      last_acked = acked;
    end
    if (arb_lost) arb_cnt = arb_cnt + 1;
    pl = drive_low;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic launch(input int len, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [1:0] sel, input logic [2:0] mask);
    @(negedge clk);
    nb = 0; done_cnt = 0; arb_cnt = 0; ack_mask = mask;
    tx_len = 5'(len);
    tx_data = '0;
    tx_data[23:0] = {b2, b1, b0};
    free_sel = sel;
    tx_start = 1'b1;
    c_set = cyc;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 20000 && done_cnt == 0 && arb_cnt == 0; k++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic check_frame(input int len, input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input int sent, input int exp_ack,
                             input int exp_delay);
    logic [7:0] bytes [3];
    int n, el, ep;
    string rq;
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    n = 1 + 10 * sent;
    chk("R2 idle wait", t_first - c_set - 1, exp_delay);
    chk("R7 bits sent", nb, n);
    for (int i = 0; i < n && i < nb; i++) begin
      if (i == 0) begin
        el = 180; ep = 220; rq = "R3 start bit";
      end else begin
        int j, b;
        j = (i - 1) % 10; b = (i - 1) / 10;
        ep = 117;
        if (j < 8) begin
          el = bytes[b][7-j] ? 29 : 73; rq = "R4 data bit";
        end else if (j == 8) begin
          el = (b == len - 1) ? 29 : 73; rq = "R5 eom bit";
        end else begin
          el = 29; rq = "R6 ack slot";
        end
      end
      chk({rq, " low"}, low_a[i], el);
      chk({rq, " period"}, per_a[i], ep);
    end
    chk("R8 done pulses", done_cnt, 1);
    chk(exp_ack != 0 ? "R6 acked" : "R7 acked", int'(last_acked), exp_ack);
    chk("R8 busy after done", int'(busy), 0);
  endtask

  function automatic int need_of(input logic [1:0] sel);
    case (sel)
      2'd0: need_of = 351;
      2'd1: need_of = 585;
      2'd2: need_of = 819;
      default: need_of = 1;
    endcase
  endfunction

  // {len, b0, b1, b2, sel, ack mask, acked, bytes sent, pad}
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {4'd1, 8'h40, 8'h00, 8'h00, 2'd3, 3'b001, 1'b1, 2'd1, 4'd0},
    {4'd2, 8'h45, 8'h36, 8'h00, 2'd0, 3'b011, 1'b1, 2'd2, 4'd0},
    {4'd3, 8'h40, 8'h82, 8'hA5, 2'd3, 3'b001, 1'b0, 2'd2, 4'd0},
    {4'd2, 8'h4F, 8'h36, 8'h00, 2'd2, 3'b000, 1'b1, 2'd2, 4'd0},
    {4'd2, 8'h4F, 8'h36, 8'h00, 2'd3, 3'b001, 1'b0, 2'd1, 4'd0},
    {4'd3, 8'h41, 8'h00, 8'hFF, 2'd1, 3'b111, 1'b1, 2'd3, 4'd0}
  };

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset drive_low", int'(drive_low), 0);
    chk("R1 reset busy", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset done", int'(done), 0);
    chk("R1 after reset arb_lost", int'(arb_lost), 0);

    for (int v = 0; v < NV; v++) begin
      logic [39:0] e;
      e = VEC[v];
      launch(int'(e[39:36]), e[35:28], e[27:20], e[19:12], e[11:10], e[9:7]);
      wait_end();
      check_frame(int'(e[39:36]), e[35:28], e[27:20], e[19:12], int'(e[5:4]),
                  int'(e[6]), need_of(e[11:10]));
      repeat (20) @(negedge clk);
    end

    // R2: a busy line restarts the idle count.
    ext_low = 1'b1;
    launch(1, 8'h40, 8'h00, 8'h00, 2'd0, 3'b001);
    repeat (99) @(negedge clk);
    ext_low = 1'b0;
    wait_end();
    check_frame(1, 8'h40, 8'h00, 8'h00, 1, 1, 99 + 351);
    repeat (20) @(negedge clk);

    // R10: a start request during a frame is ignored.
    launch(1, 8'h40, 8'h00, 8'h00, 2'd3, 3'b001);
    repeat (400) @(negedge clk);
    tx_len = 5'd2;
    tx_data[15:0] = 16'h1245;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    wait_end();
    check_frame(1, 8'h40, 8'h00, 8'h00, 1, 1, 1);
    repeat (300) @(negedge clk);
    chk("R10 no second frame busy", int'(busy), 0);
    chk("R10 no second frame bits", nb, 11);

    // R9: another initiator holds the line in a released data bit.
    launch(2, 8'h40, 8'h00, 8'h00, 2'd3, 3'b000);
    for (int k = 0; k < 5000 && !(nb == 2 && run == 90); k++) @(negedge clk);
    ext_low = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 arb pulses", arb_cnt, 1);
    chk("R9 drive released", int'(drive_low), 0);
    chk("R9 idle", int'(busy), 0);
    chk("R9 no done", done_cnt, 0);
    ext_low = 1'b0;
    repeat (300) @(negedge clk);
    chk("R9 no further bits", nb, 2);

    // R1: reset in the middle of a start bit.
    launch(1, 8'h40, 8'h00, 8'h00, 2'd3, 3'b001);
    repeat (100) @(negedge clk);
    chk("R1 pulling before reset", int'(drive_low), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-frame reset drive_low", int'(drive_low), 0);
    chk("R1 mid-frame reset busy", int'(busy), 0);
    rst = 1'b0;
    repeat (400) @(negedge clk);
    chk("R1 no bits after reset", nb, 1);
    chk("R1 no done after reset", done_cnt, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule